// File: doc/BRIEF.md
# Byte-Wide PROM Configuration Reader

This block is the bus master for a byte-wide configuration memory. After a start request it walks an external PROM through an 18-bit address range and reads one byte per address. It shifts each byte out as a serial bit stream, together with a configuration clock that it makes itself by dividing the system clock. A direction input picks the address sequence. With the input low, the first address is zero and the address counts up. With the input high, the first address is the top of the space (all ones) and the address counts down. This suits memories that are filled from either end.

The PROM is treated as asynchronous memory: the data for an address must be settled one system clock after that address is driven. The serial output has no back-pressure. A downstream slave must take each bit on the rising edge of the configuration clock, so no ready signal exists and the reader never stalls. The run length is fixed by a parameter. After the final bit, done rises, the configuration clock parks low and the data line is held at zero.

Top module: `prom_byte_cfg_reader`

## Requirements
- R1: While reset is asserted and directly after it, cfg_clk, cfg_dout and done are 0 and prom_addr is 0.
- R2: A start accepted with dir_down=0 drives prom_addr to 0 on the next cycle. After each byte is taken, the address rises by one.
- R3: A start accepted with dir_down=1 drives prom_addr to all ones (0x3FFFF at the default width) on the next cycle. After each byte is taken, the address falls by one.
- R4: The address counter wraps modulo 2^ADDR_W in both directions.
- R5: While bytes are shifted, cfg_clk has a period of CLK_DIV system cycles: low for the first half and high for the second half. It is low whenever the reader is not shifting. The first rising edge follows CLK_DIV/2 cycles after the first bit appears.
- R6: Each byte is sent most significant bit first, one bit per cfg_clk period. A bit changes only when cfg_clk goes low and is stable while cfg_clk is high.
- R7: The next address is driven while the current byte is shifting. Successive bytes follow with no idle clock period between them, so exactly BYTE_COUNT+1 distinct addresses appear in a run.
- R8: done rises 8*CLK_DIV*BYTE_COUNT+1 cycles after the cycle in which start was accepted. It then stays high with cfg_clk low until the next accepted start.
- R9: start, and any change of dir_down, has no effect while a run is in progress.
- R10: start is accepted in the idle state and in the done state, and it clears done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a run (level sampled each cycle) |
| dir_down | input | 1 | 0: count up from zero, 1: count down from all ones |
| prom_addr | output | ADDR_W | Address to the PROM |
| prom_data | input | DATA_W | Byte returned by the PROM |
| cfg_clk | output | 1 | Generated configuration clock |
| cfg_dout | output | 1 | Serial configuration data, MSB first |
| done | output | 1 | Run complete |

## Verification
The PROM is modelled as a function of the address and a seed. A wrong address order, a missing address or a reversed bit order therefore gives a different bit stream. Runs in both directions with several seeds separate the up and down sequences and catch stuck or swapped data bits. Some runs toggle start and dir_down in mid-run to show that they are ignored. The arrival time of done and the first clock edge pin down the divider ratio and the back-to-back byte timing. A narrow-address instance run past the end of its space in each direction tells correct modulo wrap apart from saturation. A reset in mid-run confirms the idle state.

// File: rtl/mpcfg_pkg.sv
package mpcfg_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FETCH = 2'd1,
    ST_SHIFT = 2'd2,
    ST_DONE  = 2'd3
  } rd_state_e;
endpackage

// File: rtl/cfg_clk_gen.sv
module cfg_clk_gen #(
  parameter int CLK_DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic cfg_clk,
  output logic period_end
);
  localparam int PW = (CLK_DIV > 2) ? $clog2(CLK_DIV) : 1;
  localparam logic [PW-1:0] LAST_PH = PW'(CLK_DIV - 1);
  localparam logic [PW-1:0] HIGH_PH = PW'(CLK_DIV / 2);

  logic [PW-1:0] phase_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= '0;
    end else if (!run || phase_q == LAST_PH) begin
      phase_q <= '0;
    end else begin
      phase_q <= phase_q + 1'b1;
    end
  end

  assign cfg_clk    = run && (phase_q >= HIGH_PH);
  assign period_end = run && (phase_q == LAST_PH);
endmodule

// File: rtl/prom_addr_ctr.sv
module prom_addr_ctr #(
  parameter int ADDR_W = 18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              down,
  input  logic              step,
  output logic [ADDR_W-1:0] addr
);
  logic dir_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr  <= '0;
      dir_q <= 1'b0;
    end else if (load) begin
      dir_q <= down;
      addr  <= down ? '1 : '0;
    end else if (step) begin
      addr  <= dir_q ? addr - 1'b1 : addr + 1'b1;
    end
  end
endmodule

// File: rtl/byte_serializer.sv
module byte_serializer #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              shift,
  input  logic [DATA_W-1:0] din,
  output logic              bit_out,
  output logic              last_bit
);
  localparam int BW = (DATA_W > 2) ? $clog2(DATA_W) : 1;
  localparam logic [BW-1:0] FINAL_BIT = BW'(DATA_W - 1);

  logic [DATA_W-1:0] shreg_q;
  logic [BW-1:0]     bcnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg_q <= '0;
      bcnt_q  <= '0;
    end else if (load) begin
      shreg_q <= din;
      bcnt_q  <= '0;
    end else if (shift) begin
      shreg_q <= {shreg_q[DATA_W-2:0], 1'b0};
      bcnt_q  <= bcnt_q + 1'b1;
    end
  end

  assign bit_out  = shreg_q[DATA_W-1];
  assign last_bit = (bcnt_q == FINAL_BIT);
endmodule

// File: rtl/prom_byte_cfg_reader.sv
module prom_byte_cfg_reader
  import mpcfg_pkg::*;
#(
  parameter int ADDR_W     = 18,
  parameter int DATA_W     = 8,
  parameter int CLK_DIV    = 4,
  parameter int BYTE_COUNT = 32768
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              dir_down,
  output logic [ADDR_W-1:0] prom_addr,
  input  logic [DATA_W-1:0] prom_data,
  output logic              cfg_clk,
  output logic              cfg_dout,
  output logic              done
);
  localparam int CW = $clog2(BYTE_COUNT + 1);
  localparam logic [CW-1:0] FINAL_CNT = CW'(BYTE_COUNT);

  rd_state_e     state_q, state_d;
  logic [CW-1:0] bytes_q;
  logic busy, run, period_end, last_bit, ser_bit;
  logic addr_load, take_byte, ser_shift, final_byte;

  assign busy       = (state_q == ST_FETCH) || (state_q == ST_SHIFT);
  assign run        = (state_q == ST_SHIFT);
  assign final_byte = (bytes_q == FINAL_CNT);
  assign addr_load  = start && !busy;
  assign take_byte  = (state_q == ST_FETCH) ||
                      (run && period_end && last_bit && !final_byte);
  assign ser_shift  = run && period_end && !last_bit;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE, ST_DONE: if (start) state_d = ST_FETCH;
      ST_FETCH:         state_d = ST_SHIFT;
      ST_SHIFT:         if (period_end && last_bit && final_byte) state_d = ST_DONE;
      default:          state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      bytes_q <= '0;
    end else begin
      state_q <= state_d;
      if (addr_load)      bytes_q <= '0;
      else if (take_byte) bytes_q <= bytes_q + 1'b1;
    end
  end

  cfg_clk_gen #(.CLK_DIV(CLK_DIV)) u_clkgen (
    .clk        (clk),
    .rst_n      (rst_n),
    .run        (run),
    .cfg_clk    (cfg_clk),
    .period_end (period_end)
  );

  prom_addr_ctr #(.ADDR_W(ADDR_W)) u_addr (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (addr_load),
    .down  (dir_down),
    .step  (take_byte),
    .addr  (prom_addr)
  );

  byte_serializer #(.DATA_W(DATA_W)) u_ser (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (take_byte),
    .shift    (ser_shift),
    .din      (prom_data),
    .bit_out  (ser_bit),
    .last_bit (last_bit)
  );

  assign cfg_dout = run && ser_bit;
  assign done     = (state_q == ST_DONE);
endmodule

// File: rtl/prom_byte_cfg_reader_chk.sv
module prom_byte_cfg_reader_chk #(
  parameter int ADDR_W = 18
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              dir_down,
  input logic              busy,
  input logic [ADDR_W-1:0] prom_addr,
  input logic              cfg_clk,
  input logic              cfg_dout,
  input logic              done
);
  logic [ADDR_W-1:0] prev_addr, prev_inc, prev_dec;
  logic prev_acc, seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_addr <= '0;
      prev_acc  <= 1'b0;
      seen      <= 1'b0;
    end else begin
      prev_addr <= prom_addr;
      prev_acc  <= start && !busy;
      seen      <= 1'b1;
    end
  end

  assign prev_inc = prev_addr + 1'b1;
  assign prev_dec = prev_addr - 1'b1;

  AST_UP_BASE: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && !dir_down) |=> (prom_addr == '0)); // R2
  AST_DOWN_BASE: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && dir_down) |=> (&prom_addr)); // R3
  AST_ADDR_UNIT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && !prev_acc && prom_addr != prev_addr) |-> (prom_addr == prev_inc || prom_addr == prev_dec)); // R4
  AST_IDLE_CLK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy) |-> (!cfg_clk && !cfg_dout)); // R5
  AST_BIT_HELD_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && cfg_clk && $past(cfg_clk)) |-> $stable(cfg_dout)); // R6
  AST_DONE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> done); // R8
  AST_BUSY_IGNORES_START: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> (busy || done)); // R9
endmodule

bind prom_byte_cfg_reader prom_byte_cfg_reader_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .dir_down  (dir_down),
  .busy      (busy),
  .prom_addr (prom_addr),
  .cfg_clk   (cfg_clk),
  .cfg_dout  (cfg_dout),
  .done      (done)
);

// File: tb/prom_byte_cfg_reader_bench.sv
module prom_byte_cfg_reader_bench;
  localparam int DIV = 4;
  localparam int NB  = 5;
  localparam logic [9:0] RUNS [4] = '{
    {1'b0, 1'b0, 8'h00}, {1'b1, 1'b1, 8'hA5},
    {1'b0, 1'b1, 8'h3C}, {1'b1, 1'b0, 8'hFF}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, dir_down = 1'b0;
  logic [7:0] seed = 8'h00;
  logic [17:0] prom_addr;
  logic [7:0] prom_data;
  logic cfg_clk, cfg_dout, done;
  logic w_start = 1'b0, w_dir = 1'b0;
  logic [2:0] w_addr;
  logic w_clk_o, w_dout, w_done;
  int checks = 0, fails = 0, cycles = 0;

  always #2 clk = ~clk;

  function automatic logic [7:0] pat(input logic [17:0] a, input logic [7:0] s);
    return a[7:0] ^ {a[15:10], a[17:16]} ^ s;
  endfunction

  assign prom_data = pat(prom_addr, seed);

  prom_byte_cfg_reader #(.ADDR_W(18), .DATA_W(8), .CLK_DIV(DIV), .BYTE_COUNT(NB))
  u_prom_byte_cfg_reader (
    .clk(clk), .rst_n(rst_n), .start(start), .dir_down(dir_down),
    .prom_addr(prom_addr), .prom_data(prom_data),
    .cfg_clk(cfg_clk), .cfg_dout(cfg_dout), .done(done));

  prom_byte_cfg_reader #(.ADDR_W(3), .DATA_W(8), .CLK_DIV(2), .BYTE_COUNT(10))
  u_wrap (
    .clk(clk), .rst_n(rst_n), .start(w_start), .dir_down(w_dir),
    .prom_addr(w_addr), .prom_data(8'h5A),
    .cfg_clk(w_clk_o), .cfg_dout(w_dout), .done(w_done));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=<150000", cycles);
      finish_run();
    end
  end

  task automatic do_run(input logic dn, input logic stray, input logic [7:0] sd);
    logic [17:0] base, exp_a, last_a;
    logic [7:0] exp_byte;
    logic prev_clk;
    int idx, naddr, addr_err, nbits, bit_err, first_rise, high_cnt, tail_rises;
    @(negedge clk);
    dir_down = dn; seed = sd; start = 1'b1;
    @(negedge clk);
    start = 1'b0; idx = 1;
    base = dn ? 18'h3FFFF : 18'h00000;
    check(prom_addr == base, dn ? "R3 first address" : "R2 first address", prom_addr, base);
    check(!done, "R10 done cleared", done, 0);
    naddr = 1; last_a = prom_addr; prev_clk = cfg_clk;
    addr_err = 0; nbits = 0; bit_err = 0; first_rise = 0; high_cnt = 0;
    while (!done && idx < 5000) begin
      @(negedge clk);
      idx++;
      if (stray) begin
        start = (idx == 30) || (idx == 31);
        dir_down = ~dn;
      end
      if (prom_addr != last_a) begin
        exp_a = dn ? base - 18'(naddr) : base + 18'(naddr);
        if (prom_addr != exp_a) addr_err++;
        naddr++;
        last_a = prom_addr;
      end
      if (cfg_clk) high_cnt++;
      if (cfg_clk && !prev_clk) begin
        if (first_rise == 0) first_rise = idx;
        exp_a = dn ? base - 18'(nbits / 8) : base + 18'(nbits / 8);
        exp_byte = pat(exp_a, sd);
        if (cfg_dout != exp_byte[7 - (nbits % 8)]) bit_err++;
        nbits++;
      end
      prev_clk = cfg_clk;
    end
    start = 1'b0;
    check(done, "R8 done reached", done, 1);
    check(idx == 2 + 8 * NB * DIV, "R8 done timing", idx, 2 + 8 * NB * DIV);
    check(first_rise == 2 + DIV / 2, "R5 first rising edge", first_rise, 2 + DIV / 2);
    check(high_cnt == 8 * NB * DIV / 2, "R5 high phase length", high_cnt, 8 * NB * DIV / 2);
    check(nbits == 8 * NB, "R6 bit count", nbits, 8 * NB);
    check(bit_err == 0, "R6 MSB-first stream", bit_err, 0);
    check(naddr == NB + 1, "R7 distinct addresses", naddr, NB + 1);
    check(addr_err == 0, dn ? "R3 down sequence" : "R2 up sequence", addr_err, 0);
    if (stray) check(naddr == NB + 1 && addr_err == 0 && bit_err == 0,
                     "R9 mid-run start ignored", addr_err + bit_err, 0);
    tail_rises = 0;
    prev_clk = cfg_clk;
    for (int t = 0; t < 3 * DIV; t++) begin
      @(negedge clk);
      if (cfg_clk && !prev_clk) tail_rises++;
      prev_clk = cfg_clk;
    end
    check(tail_rises == 0 && !cfg_clk && !cfg_dout, "R5 clock parked after done", tail_rises, 0);
    check(done, "R8 done holds", done, 1);
  endtask

  task automatic wrap_run(input logic dn, input logic [2:0] exp_final);
    int guard;
    @(negedge clk);
    w_dir = dn; w_start = 1'b1;
    @(negedge clk);
    w_start = 1'b0;
    guard = 0;
    while (!w_done && guard < 1000) begin
      @(negedge clk);
      guard++;
    end
    check(w_done && w_addr == exp_final, "R4 wrap modulo", w_addr, exp_final);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(!cfg_clk && !cfg_dout && !done && prom_addr == 18'h0, "R1 in reset",
          {cfg_clk, cfg_dout, done}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!cfg_clk && !cfg_dout && !done && prom_addr == 18'h0, "R1 after reset",
          prom_addr, 0);

    for (int r = 0; r < 4; r++) begin
      do_run(RUNS[r][9], RUNS[r][8], RUNS[r][7:0]);
    end

    wrap_run(1'b0, 3'd2);
    wrap_run(1'b1, 3'd5);

    @(negedge clk);
    dir_down = 1'b1; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (20) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check(!cfg_clk && !cfg_dout && !done && prom_addr == 18'h0, "R1 mid-run reset",
          prom_addr, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(!done && !cfg_clk, "R1 idle after reset", done, 0);

    finish_run();
  end
endmodule